// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a memory-mapped event timer. A 64-bit up-counter runs while a global run bit is set. Three comparator channels watch the low 32 bits of that counter. Software reaches every register through a single-cycle 32-bit write strobe and a combinational read port.

Each channel can be set up in several ways:
- It fires once (one-shot) or repeats at a fixed reload period (periodic).
- It signals by a one-cycle pulse (edge) or by a sticky status bit (level).
- It delivers the event on an interrupt line chosen by a routing field, or as a message write with its own address and data.

A global legacy bit takes channel 0 and channel 1 off the routed lines. Channel 0 then drives a dedicated tick output and channel 1 a dedicated clock-calendar output.

Matching is wrap-aware. An armed channel fires on the first clock edge at which the counter low word minus the compare value is non-negative as a signed 32-bit number. The fire takes effect at that same edge, so an output sampled just after it shows a counter one higher than the compare value.

Top module: `mcmp_event_timer`

## Requirements
- R1: Global configuration (0x010) bit 0 runs the counter, which then grows by exactly one per clock. With bit 0 clear, the counter holds.
- R2: The counter low word sits at 0xF0 and the high word at 0xF4. Both are writable only while the counter is halted; writes made while it runs are ignored.
- R3: Address 0x000 reads the channel count minus one in bits [12:8] and a legacy-capable flag in bit 15. Address 0x004 reads the tick period in femtoseconds (parameter, default 69841279).
- R4: The channel n configuration register sits at 0x100+0x20n with these bits: 0 enable, 1 periodic, 2 level, 3 value-set, 4 32-bit mode, 5 message enable, 6 message capable, 7 periodic capable, [12:8] route. Bits 4, 6 and 7 always read 1, so a cleared register reads 0xD0.
- R5: In one-shot mode an armed channel fires exactly once, at the first edge where the signed 32-bit value (counter low − compare) is ≥ 0. This includes across a 32-bit wrap, and a compare value already passed fires on the next edge.
- R6: In periodic mode, a compare write while value-set is 1 loads the match value and clears value-set. A later compare write loads the period, and every fire adds that period to the match value.
- R7: A compare write that loads the match value (0x108+0x20n) reads back on the very next read, and the match uses it from the next edge.
- R8: In level mode a fire sets status bit n (0x020). The channel's output stays high until software writes 1 to that bit. In edge mode the output is a one-cycle pulse and the status bit stays clear.
- R9: Unless taken by legacy routing, an enabled channel signals on `irq_lines[route]` and on no other line.
- R10: With global bit 1 set, channel 0 signals only on `tick_irq` and channel 1 only on `rtc_irq`, never on `irq_lines`.
- R11: With message enable set, a fire pulses `msg_valid[n]` for one cycle. It presents the route high word (0x114+0x20n) as address and the route low word (0x110+0x20n) as data, and drives no interrupt line.
- R12: A channel with enable clear raises no line, sets no status bit and sends no message, even when it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_lines | output | 32 | Routed interrupt lines |
| tick_irq | output | 1 | Legacy tick output (channel 0) |
| rtc_irq | output | 1 | Legacy clock-calendar output (channel 1) |
| msg_valid | output | 3 | Per-channel message write strobe |
| msg_addr | output | 96 | Per-channel message address, channel n at [32n+31:32n] |
| msg_data | output | 96 | Per-channel message data, channel n at [32n+31:32n] |

## Verification
The one-shot assertion assumes that no compare write and no switch out of periodic mode lands on the edge that fires. Given that, a pulse is never followed by a second one. The stimulus meets this by reprogramming a channel only while the counter is halted and after its fire has been seen or the channel disabled. The level-hold assertion assumes that status is cleared only by an explicit write of 1. The bench issues such writes only once the status bit has been checked.

// File: rtl/mcmp_event_timer.sv
module mcmp_event_timer #(
  parameter int          NUM_CH    = 3,
  parameter int          NUM_LINES = 32,
  parameter logic [31:0] PERIOD_FS = 32'd69841279,
  parameter int          AW        = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 tick_irq,
  output logic                 rtc_irq,
  output logic [NUM_CH-1:0]    msg_valid,
  output logic [NUM_CH*32-1:0] msg_addr,
  output logic [NUM_CH*32-1:0] msg_data
);
  localparam int RW = $clog2(NUM_LINES);
  localparam logic [AW-1:0] A_CAP = AW'('h000), A_PER = AW'('h004), A_GCFG = AW'('h010),
                            A_STS = AW'('h020), A_CLO = AW'('h0F0), A_CHI = AW'('h0F4);

  logic [63:0] cnt;
  logic g_en, g_leg;
  logic [NUM_CH-1:0] status, pulse, armed, hit, chint;
  logic [NUM_CH-1:0] c_en, c_per, c_lvl, c_vs, c_msg;
  logic [NUM_CH-1:0] cfg_w, cmp_w, rlo_w, rhi_w;
  logic [RW-1:0] c_rt [NUM_CH];
  logic [31:0] cmp [NUM_CH];
  logic [31:0] prd [NUM_CH];
  logic [31:0] rlo [NUM_CH];
  logic [31:0] rhi [NUM_CH];
  logic ch_space;

  assign ch_space = addr[AW-1:8] == (AW-8)'(1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [31:0] diff;
    assign diff     = cnt[31:0] - cmp[g];
    assign hit[g]   = ~diff[31];
    assign cfg_w[g] = wr_en && ch_space && addr[7:5] == 3'(g) && addr[4:0] == 5'h00;
    assign cmp_w[g] = wr_en && ch_space && addr[7:5] == 3'(g) && addr[4:0] == 5'h08;
    assign rlo_w[g] = wr_en && ch_space && addr[7:5] == 3'(g) && addr[4:0] == 5'h10;
    assign rhi_w[g] = wr_en && ch_space && addr[7:5] == 3'(g) && addr[4:0] == 5'h14;
    assign chint[g] = c_en[g] && !c_msg[g] && (c_lvl[g] ? status[g] : pulse[g]);
    assign msg_addr[32*g +: 32] = rhi[g];
    assign msg_data[32*g +: 32] = rlo[g];

    assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g] && !(wr_en && addr == A_STS && wdata[g])) |=> status[g]);
    assert_status_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[g]) |-> $past(c_en[g] && c_lvl[g]));
    assert_msg_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid[g] |-> $past(c_en[g] && c_msg[g]));
    assert_oneshot_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse[g] && !$past(c_per[g]) && !$past(cmp_w[g])) |=> !pulse[g]);
  end

  assign tick_irq = g_leg && chint[0];
  assign rtc_irq  = g_leg && chint[1];

  always_comb begin
    irq_lines = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (chint[n] && !(g_leg && n < 2)) irq_lines[c_rt[n]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; g_en <= 1'b0; g_leg <= 1'b0;
      status <= '0; pulse <= '0; armed <= '0; msg_valid <= '0;
      c_en <= '0; c_per <= '0; c_lvl <= '0; c_vs <= '0; c_msg <= '0;
      for (int n = 0; n < NUM_CH; n++) begin
        c_rt[n] <= '0; cmp[n] <= '0; prd[n] <= '0; rlo[n] <= '0; rhi[n] <= '0;
      end
    end else begin
      if (g_en) cnt <= cnt + 64'd1;
      if (wr_en && !g_en && addr == A_CLO) cnt[31:0]  <= wdata;
      if (wr_en && !g_en && addr == A_CHI) cnt[63:32] <= wdata;
      if (wr_en && addr == A_GCFG) {g_leg, g_en} <= wdata[1:0];
      for (int n = 0; n < NUM_CH; n++) begin
        pulse[n]     <= 1'b0;
        msg_valid[n] <= 1'b0;
        if (wr_en && addr == A_STS && wdata[n]) status[n] <= 1'b0;
        if (armed[n] && hit[n]) begin
          if (c_per[n]) cmp[n] <= cmp[n] + prd[n];
          else          armed[n] <= 1'b0;
          if (c_en[n]) begin
            if (c_msg[n])      msg_valid[n] <= 1'b1;
            else if (c_lvl[n]) status[n]    <= 1'b1;
            else               pulse[n]     <= 1'b1;
          end
        end
        if (cfg_w[n]) begin
          c_en[n] <= wdata[0]; c_per[n] <= wdata[1]; c_lvl[n] <= wdata[2];
          c_vs[n] <= wdata[3]; c_msg[n] <= wdata[5]; c_rt[n]  <= wdata[8 +: RW];
        end
        if (cmp_w[n]) begin
          if (c_per[n] && !c_vs[n]) prd[n] <= wdata;
          else begin
            cmp[n]   <= wdata;
            armed[n] <= 1'b1;
            c_vs[n]  <= 1'b0;
          end
        end
        if (rlo_w[n]) rlo[n] <= wdata;
        if (rhi_w[n]) rhi[n] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ch_space) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (addr[7:5] == 3'(n)) begin
          case (addr[4:0])
            5'h00: begin
              rdata[0] = c_en[n]; rdata[1] = c_per[n]; rdata[2] = c_lvl[n];
              rdata[3] = c_vs[n]; rdata[4] = 1'b1;     rdata[5] = c_msg[n];
              rdata[6] = 1'b1;    rdata[7] = 1'b1;     rdata[8 +: RW] = c_rt[n];
            end
            5'h08:   rdata = cmp[n];
            5'h10:   rdata = rlo[n];
            5'h14:   rdata = rhi[n];
            default: rdata = '0;
          endcase
        end
      end
    end else begin
      case (addr)
        A_CAP:   begin rdata[12:8] = 5'(NUM_CH - 1); rdata[15] = 1'b1; end
        A_PER:   rdata = PERIOD_FS;
        A_GCFG:  rdata[1:0] = {g_leg, g_en};
        A_STS:   rdata[NUM_CH-1:0] = status;
        A_CLO:   rdata = cnt[31:0];
        A_CHI:   rdata = cnt[63:32];
        default: rdata = '0;
      endcase
    end
  end

  assert_hold_when_halted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!g_en && !(wr_en && (addr == A_CLO || addr == A_CHI))) |=> $stable(cnt));
  assert_step_when_running_R1: assert property (@(posedge clk) disable iff (!rst_n)
    g_en |=> cnt == $past(cnt) + 64'd1);
endmodule

// File: tb/sim_mcmp_event_timer.sv
module sim_mcmp_event_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] irq_lines;
  logic tick_irq, rtc_irq;
  logic [2:0] msg_valid;
  logic [95:0] msg_addr, msg_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mcmp_event_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_lines(irq_lines), .tick_irq(tick_irq), .rtc_irq(rtc_irq),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data));

  function automatic logic [11:0] chreg(int ch, int off);
    return 12'(32'h100 + 32'h20 * ch + off);
  endfunction
  function automatic logic [31:0] exp_fire(logic [31:0] start, logic [31:0] dlt);
    return start + dlt + 32'd1;
  endfunction
  function automatic logic sig(int sel);
    if (sel < 32) return irq_lines[sel];
    if (sel == 32) return tick_irq;
    if (sel == 33) return rtc_irq;
    return msg_valid[sel-40];
  endfunction

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask
  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, 96'(v), 96'(e));
  endtask
  task automatic wait_sig(input int sel, input int maxc, input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(negedge clk); #1;
      seen = sig(sel);
    end
    check(seen, req, 96'(seen), 96'd1);
  endtask
  task automatic setcnt(input logic [31:0] lo, input logic [31:0] hi);
    wr(12'h010, 32'h0); wr(12'h0F0, lo); wr(12'h0F4, hi);
  endtask
  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, v2;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_rd(12'h010, 32'h0, "R1 reset cfg");
    chk_rd(12'h0F0, 32'h0, "R1 reset counter");
    chk_rd(12'h000, 32'h0000_8200, "R3 capability");
    chk_rd(12'h004, 32'd69841279, "R3 period");
    chk_rd(chreg(1, 0), 32'hD0, "R4 channel cfg reset");
    check(irq_lines == 0 && msg_valid == 0, "R9 lines quiet", 96'(irq_lines), 96'd0);

    // counter writes and run control
    setcnt(32'h100, 32'h2);
    chk_rd(12'h0F0, 32'h100, "R2 low write halted");
    chk_rd(12'h0F4, 32'h2, "R2 high write halted");
    wr(12'h010, 32'h1);
    repeat (10) @(negedge clk);
    chk_rd(12'h0F0, 32'h10A, "R1 counts one per clock");
    rd(12'h0F0, v);
    wr(12'h0F0, 32'h0);
    chk_rd(12'h0F0, v + 1, "R2 write ignored while running");
    chk_rd(12'h0F4, 32'h2, "R2 high unchanged");
    wr(12'h010, 32'h0);
    rd(12'h0F0, v);
    repeat (5) @(negedge clk);
    chk_rd(12'h0F0, v, "R1 halted holds");

    // one-shot edge, channel 0, route 5
    setcnt(32'd1000, 32'd0);
    wr(chreg(0, 8), 32'd1050);
    chk_rd(chreg(0, 8), 32'd1050, "R7 compare readback");
    wr(chreg(0, 0), 32'h501);
    wr(12'h010, 32'h1);
    wait_sig(5, 200, "R5 one-shot fired", seen);
    check(irq_lines == 32'h20, "R9 only routed line", 96'(irq_lines), 96'h20);
    chk_rd(12'h0F0, 32'd1051, "R5 fire count");
    chk_rd(12'h020, 32'h0, "R8 edge leaves status");
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); #1; if (irq_lines[5]) seen = 1'b1; end
    check(!seen, "R5 fires only once", 96'(seen), 96'd0);

    // level, channel 1, route 9
    setcnt(32'd2000, 32'd0);
    wr(chreg(1, 8), 32'd2010);
    wr(chreg(1, 0), 32'h905);
    wr(12'h010, 32'h1);
    wait_sig(9, 200, "R8 level fired", seen);
    chk_rd(12'h0F0, 32'd2011, "R5 level fire count");
    repeat (20) @(negedge clk);
    #1 check(irq_lines[9] == 1'b1, "R8 level held", 96'(irq_lines), 96'h200);
    chk_rd(12'h020, 32'h2, "R8 status set");
    wr(12'h020, 32'h2);
    #1 check(irq_lines[9] == 1'b0, "R8 cleared by write one", 96'(irq_lines), 96'h0);

    // wrap, channel 2, route 12
    setcnt(32'hFFFF_FFF0, 32'd0);
    wr(chreg(2, 8), 32'd5);
    wr(chreg(2, 0), 32'hC01);
    wr(12'h010, 32'h1);
    wait_sig(12, 200, "R5 wrap fired", seen);
    chk_rd(12'h0F0, 32'd6, "R5 wrap fire count");
    chk_rd(12'h0F4, 32'd1, "R5 wrap high word");

    // compare already passed while halted
    setcnt(32'd500, 32'd0);
    wr(chreg(0, 8), 32'd400);
    wait_sig(5, 5, "R5 passed compare fires", seen);
    chk_rd(12'h0F0, 32'd500, "R5 passed compare count");

    // periodic, channel 0
    setcnt(32'd0, 32'd0);
    wr(chreg(0, 0), 32'h50B);
    wr(chreg(0, 8), 32'd20);
    chk_rd(chreg(0, 0), 32'h5D3, "R6 value-set self clears");
    chk_rd(chreg(0, 8), 32'd20, "R7 match value readback");
    wr(chreg(0, 8), 32'd10);
    chk_rd(chreg(0, 8), 32'd20, "R6 second write is period");
    wr(12'h010, 32'h1);
    for (int k = 0; k < 4; k++) begin
      wait_sig(5, 50, "R6 periodic fire", seen);
      chk_rd(12'h0F0, 32'(21 + 10 * k), "R6 periodic count");
      chk_rd(chreg(0, 8), 32'(30 + 10 * k), "R6 match advances");
    end
    wr(12'h010, 32'h0);
    wr(chreg(0, 0), 32'h0);

    // legacy routing
    wr(12'h010, 32'h2);
    setcnt(32'd0, 32'd0);
    wr(12'h010, 32'h2);
    wr(chreg(0, 0), 32'h501);
    wr(chreg(0, 8), 32'd8);
    wr(chreg(1, 0), 32'h905);
    wr(chreg(1, 8), 32'd12);
    wr(12'h010, 32'h3);
    wait_sig(32, 50, "R10 tick output", seen);
    check(irq_lines == 0, "R10 channel 0 off routed lines", 96'(irq_lines), 96'd0);
    chk_rd(12'h0F0, 32'd9, "R10 tick count");
    wait_sig(33, 50, "R10 rtc output", seen);
    check(irq_lines == 0, "R10 channel 1 off routed lines", 96'(irq_lines), 96'd0);
    chk_rd(12'h0F0, 32'd13, "R10 rtc count");
    wr(12'h020, 32'h2);
    #1 check(rtc_irq == 1'b0, "R10 rtc cleared", 96'(rtc_irq), 96'd0);
    wr(12'h010, 32'h0);

    // message delivery, channel 2
    setcnt(32'd0, 32'd0);
    wr(chreg(2, 16), 32'hCAFE_0042);
    wr(chreg(2, 20), 32'hFEE0_0000);
    wr(chreg(2, 0), 32'hC21);
    wr(chreg(2, 8), 32'd30);
    wr(12'h010, 32'h1);
    wait_sig(42, 100, "R11 message strobe", seen);
    check(msg_addr[95:64] == 32'hFEE0_0000, "R11 message address", 96'(msg_addr[95:64]), 96'hFEE0_0000);
    check(msg_data[95:64] == 32'hCAFE_0042, "R11 message data", 96'(msg_data[95:64]), 96'hCAFE_0042);
    check(irq_lines == 0, "R11 no line", 96'(irq_lines), 96'd0);
    chk_rd(12'h0F0, 32'd31, "R11 message count");
    @(negedge clk); #1;
    check(msg_valid == 0, "R11 strobe one cycle", 96'(msg_valid), 96'd0);

    // disabled channels
    setcnt(32'd0, 32'd0);
    wr(chreg(1, 0), 32'h904);
    wr(chreg(1, 8), 32'd5);
    wr(chreg(2, 0), 32'hC20);
    wr(chreg(2, 8), 32'd5);
    wr(12'h010, 32'h1);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); #1; if (irq_lines != 0 || msg_valid != 0) seen = 1'b1; end
    check(!seen, "R12 disabled channel silent", 96'(seen), 96'd0);
    chk_rd(12'h020, 32'h0, "R12 no status");

    // random one-shots
    for (int it = 0; it < 12; it++) begin
      int ch, rt;
      bit lvl;
      logic [31:0] st, dl;
      ch = int'($urandom % 3); rt = int'($urandom % 32); lvl = 1'($urandom);
      st = $urandom & 32'h7FFF_FFFF; dl = 32'd1 + ($urandom % 150);
      setcnt(st, 32'd0);
      for (int c = 0; c < 3; c++) wr(chreg(c, 0), 32'h0);
      wr(12'h020, 32'h7);
      wr(chreg(ch, 8), st + dl);
      wr(chreg(ch, 0), 32'(rt << 8) | (lvl ? 32'h5 : 32'h1));
      wr(12'h010, 32'h1);
      wait_sig(rt, 300, "R9 random fire", seen);
      check(irq_lines == (32'h1 << rt), "R9 random route", 96'(irq_lines), 96'(32'h1 << rt));
      rd(12'h0F0, v2);
      check(v2 == exp_fire(st, dl), "R5 random fire count", 96'(v2), 96'(exp_fire(st, dl)));
      if (lvl) chk_rd(12'h020, 32'(1 << ch), "R8 random status");
    end
    finish_up();
  end
endmodule